// File: doc/BRIEF.md
# Code Segment Load Checker

This block decides whether a far control transfer may install a new code segment. The caller presents a decoded descriptor, the target selector, the requested privilege and the current privilege, plus a flag saying long mode is active, and pulses a strobe. One cycle later the block reports either success or a fault kind with an error code.

The checks run in a fixed order: segment type, then the long/default-size conflict, then privilege, then presence. Only the first failure is reported. Conforming and non-conforming code follow different privilege rules.

On success the block updates its copy of the code segment register. The stored selector takes the caller's privilege in its two low bits, and the copy is marked valid. The block also latches the resulting execution mode and emits a one-cycle flush pulse for the instruction fetch path.

Top module: `cseg_load_checker`

## Requirements
- R1: After reset, `done_o`, `flush_o` and `cs_valid_o` are 0, `cs_sel_o` is 0, `mode_o` is 0 (legacy) and `fault_o` is 0 (none).
- R2: The fault kind is encoded as 0 none, 1 general protection and 2 not present. A general-protection fault results when the descriptor is invalid, when it is a system descriptor (`desc_seg_i`=0), or when its type is data (`desc_type_i[3]`=0).
- R3: With `lma_i`=1, a descriptor that has both `desc_l_i` and `desc_db_i` set raises a general-protection fault. With `lma_i`=0 this conflict is not checked.
- R4: For non-conforming code (`desc_type_i[2]`=0), a general-protection fault results when the DPL differs from `cpl_i` or when `rpl_i` is greater than `cpl_i`.
- R5: For conforming code (`desc_type_i[2]`=1), a general-protection fault results when the DPL is greater than `cpl_i`. RPL is not checked.
- R6: A not-present fault is reported only when every earlier check passes and `desc_present_i`=0. For either fault, `err_code_o` equals `sel_i` with bits 1:0 cleared.
- R7: On success, `fault_o`=0, `err_code_o`=0, `cs_sel_o` = {`sel_i`[15:2], `cpl_i`} and `cs_valid_o`=1.
- R8: On success, `mode_o` becomes 2 (64-bit) when `lma_i`=1 and `desc_l_i`=1, 1 (compatibility) when `lma_i`=1 and `desc_l_i`=0, and 0 (legacy) when `lma_i`=0.
- R9: `flush_o` is high for exactly the cycle after each successful request. A faulting request leaves `cs_sel_o`, `cs_valid_o` and `mode_o` unchanged.
- R10: `done_o` is high in the cycle after each cycle in which `req_i` is high. `fault_o` and `err_code_o` hold their values until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Check strobe |
| desc_valid_i | input | 1 | Descriptor valid |
| desc_seg_i | input | 1 | 1 = code/data segment, 0 = system |
| desc_type_i | input | 4 | Type; bit 3 code, bit 2 conforming |
| desc_dpl_i | input | 2 | Descriptor privilege level |
| desc_present_i | input | 1 | Present bit |
| desc_l_i | input | 1 | 64-bit code flag |
| desc_db_i | input | 1 | Default operand size flag |
| sel_i | input | 16 | Target selector |
| rpl_i | input | 2 | Requested privilege level |
| cpl_i | input | 2 | Current privilege level |
| lma_i | input | 1 | Long mode active |
| done_o | output | 1 | Result valid pulse |
| fault_o | output | 2 | Fault kind |
| err_code_o | output | 16 | Fault error code |
| cs_sel_o | output | 16 | Stored code selector |
| cs_valid_o | output | 1 | Stored descriptor valid |
| mode_o | output | 2 | Execution mode |
| flush_o | output | 1 | Fetch flush pulse |

## Verification
The bench aims at the priority boundaries. A non-present descriptor is also given a privilege error, and a design that tested presence too early would report a not-present fault in place of the general-protection fault. The L/D conflict is sent both with and without long mode, which catches a design that checks it regardless of mode. A conforming segment is sent with a large RPL, which catches a design that applies the non-conforming rules to it.

The stored selector is checked after a CPL that differs from the selector's own RPL, which exposes a design that kept the original low bits. Faulting requests placed between successes catch state that gets corrupted on failure.

// File: rtl/cseg_pkg.sv
package cseg_pkg;
  localparam int PL_W   = 2;
  localparam int TYPE_W = 4;
  localparam int CODE_BIT = 3;
  localparam int CONF_BIT = 2;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_NP   = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_COMPAT = 2'd1,
    MODE_64     = 2'd2
  } mode_e;

  typedef struct packed {
    logic              valid;
    logic              seg;
    logic [TYPE_W-1:0] typ;
    logic [PL_W-1:0]   dpl;
    logic              present;
    logic              l;
    logic              db;
  } desc_t;
endpackage

// File: rtl/cseg_check.sv
module cseg_check
  import cseg_pkg::*;
(
  input  desc_t           desc_i,
  input  logic [PL_W-1:0] rpl_i,
  input  logic [PL_W-1:0] cpl_i,
  input  logic            lma_i,
  output fault_e          fault_o
);
  logic type_bad, ld_bad, priv_bad, conf;

  assign type_bad = !desc_i.valid || !desc_i.seg || !desc_i.typ[CODE_BIT];
  // conflict only meaningful when long mode is active
  assign ld_bad   = lma_i && desc_i.l && desc_i.db;
  assign conf     = desc_i.typ[CONF_BIT];
  assign priv_bad = conf ? (desc_i.dpl > cpl_i)
                         : ((desc_i.dpl != cpl_i) || (rpl_i > cpl_i));

  always_comb begin
    if (type_bad)             fault_o = FLT_GP;
    else if (ld_bad)          fault_o = FLT_GP;
    else if (priv_bad)        fault_o = FLT_GP;
    else if (!desc_i.present) fault_o = FLT_NP;
    else                      fault_o = FLT_NONE;
  end
endmodule

// File: rtl/cseg_mode.sv
module cseg_mode
  import cseg_pkg::*;
(
  input  logic  lma_i,
  input  logic  l_i,
  output mode_e mode_o
);
  always_comb begin
    if (!lma_i)   mode_o = MODE_LEGACY;
    else if (l_i) mode_o = MODE_64;
    else          mode_o = MODE_COMPAT;
  end
endmodule

// File: rtl/cseg_state.sv
module cseg_state
  import cseg_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  fault_e           fault_i,
  input  mode_e            mode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [PL_W-1:0]  cpl_i,
  output logic             done_o,
  output fault_e           fault_o,
  output logic [SEL_W-1:0] err_code_o,
  output logic [SEL_W-1:0] cs_sel_o,
  output logic             cs_valid_o,
  output mode_e            mode_o,
  output logic             flush_o
);
  logic ok;
  assign ok = (fault_i == FLT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      flush_o    <= 1'b0;
      fault_o    <= FLT_NONE;
      err_code_o <= '0;
      cs_sel_o   <= '0;
      cs_valid_o <= 1'b0;
      mode_o     <= MODE_LEGACY;
    end else begin
      done_o  <= req_i;
      flush_o <= req_i && ok;
      if (req_i) begin
        fault_o    <= fault_i;
        err_code_o <= ok ? '0 : {sel_i[SEL_W-1:PL_W], {PL_W{1'b0}}};
        if (ok) begin
          cs_sel_o   <= {sel_i[SEL_W-1:PL_W], cpl_i};
          cs_valid_o <= 1'b1;
          mode_o     <= mode_i;
        end
      end
    end
  end

  p_flush_ok_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (done_o && fault_o == FLT_NONE));
  p_err_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o != FLT_NONE) |-> (err_code_o[PL_W-1:0] == '0));
  p_sel_rpl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (cs_sel_o[PL_W-1:0] == $past(cpl_i) && cs_valid_o));
  p_hold_fault_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o != FLT_NONE) |-> ($stable(cs_sel_o) && $stable(mode_o)));
  p_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);
endmodule

// File: rtl/cseg_load_checker.sv
module cseg_load_checker
  import cseg_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             desc_valid_i,
  input  logic             desc_seg_i,
  input  logic [3:0]       desc_type_i,
  input  logic [1:0]       desc_dpl_i,
  input  logic             desc_present_i,
  input  logic             desc_l_i,
  input  logic             desc_db_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       rpl_i,
  input  logic [1:0]       cpl_i,
  input  logic             lma_i,
  output logic             done_o,
  output logic [1:0]       fault_o,
  output logic [SEL_W-1:0] err_code_o,
  output logic [SEL_W-1:0] cs_sel_o,
  output logic             cs_valid_o,
  output logic [1:0]       mode_o,
  output logic             flush_o
);
  desc_t  desc;
  fault_e chk_fault, st_fault;
  mode_e  nxt_mode, st_mode;

  assign desc = '{valid: desc_valid_i, seg: desc_seg_i, typ: desc_type_i,
                  dpl: desc_dpl_i, present: desc_present_i,
                  l: desc_l_i, db: desc_db_i};

  cseg_check u_check (
    .desc_i (desc),
    .rpl_i  (rpl_i),
    .cpl_i  (cpl_i),
    .lma_i  (lma_i),
    .fault_o(chk_fault)
  );

  cseg_mode u_mode (
    .lma_i (lma_i),
    .l_i   (desc_l_i),
    .mode_o(nxt_mode)
  );

  cseg_state #(.SEL_W(SEL_W)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .fault_i   (chk_fault),
    .mode_i    (nxt_mode),
    .sel_i     (sel_i),
    .cpl_i     (cpl_i),
    .done_o    (done_o),
    .fault_o   (st_fault),
    .err_code_o(err_code_o),
    .cs_sel_o  (cs_sel_o),
    .cs_valid_o(cs_valid_o),
    .mode_o    (st_mode),
    .flush_o   (flush_o)
  );

  assign fault_o = st_fault;
  assign mode_o  = st_mode;

  p_np_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && desc_present_i) |=> (fault_o != FLT_NP));
  p_legacy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !lma_i) |=> (mode_o == MODE_LEGACY || !flush_o));
  p_ld_gp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && lma_i && desc_l_i && desc_db_i) |=> (fault_o == FLT_GP));
endmodule

// File: tb/cseg_load_checker_tb.sv
module cseg_load_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        dv = 1'b0, ds = 1'b0, dp = 1'b0, dl = 1'b0, ddb = 1'b0, lma = 1'b0;
  logic [3:0]  dt = '0;
  logic [1:0]  ddpl = '0, rpl = '0, cpl = '0;
  logic [15:0] sel = '0;
  logic        done, cs_valid, flush;
  logic [1:0]  fault, mode;
  logic [15:0] err, cs_sel;

  int n_tests = 0, n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  logic [15:0] m_sel = '0;
  logic        m_valid = 1'b0;
  logic [1:0]  m_mode = 2'd0;

  always #2 clk = ~clk;

  cseg_load_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .desc_valid_i(dv), .desc_seg_i(ds), .desc_type_i(dt), .desc_dpl_i(ddpl),
    .desc_present_i(dp), .desc_l_i(dl), .desc_db_i(ddb),
    .sel_i(sel), .rpl_i(rpl), .cpl_i(cpl), .lma_i(lma),
    .done_o(done), .fault_o(fault), .err_code_o(err), .cs_sel_o(cs_sel),
    .cs_valid_o(cs_valid), .mode_o(mode), .flush_o(flush)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // returns expected fault kind, names deciding rule
  function automatic int exp_fault(output string rq);
    if (!dv || !ds || !dt[3]) begin rq = "R2"; return 1; end
    if (lma && dl && ddb)     begin rq = "R3"; return 1; end
    if (!dt[2]) begin
      if (ddpl != cpl || rpl > cpl) begin rq = "R4"; return 1; end
    end else if (ddpl > cpl) begin rq = "R5"; return 1; end
    if (!dp) begin rq = "R6"; return 2; end
    rq = "R7";
    return 0;
  endfunction

  task automatic run(input logic v, s, input logic [3:0] t, input logic [1:0] d,
                     input logic p, l, db, input logic [15:0] sl,
                     input logic [1:0] r, c, input logic lm);
    string rq;
    int ef;
    logic [15:0] ee;
    @(negedge clk);
    dv = v; ds = s; dt = t; ddpl = d; dp = p; dl = l; ddb = db;
    sel = sl; rpl = r; cpl = c; lma = lm; req = 1'b1;
    ef = exp_fault(rq);
    ee = (ef != 0) ? {sl[15:2], 2'b00} : 16'h0;
    if (ef == 0) begin
      m_sel = {sl[15:2], c}; m_valid = 1'b1;
      m_mode = !lm ? 2'd0 : (l ? 2'd2 : 2'd1);
    end
    @(negedge clk);
    req = 1'b0;
    chk(done == 1'b1, "R10 done", int'(done), 1);
    chk(fault == ef[1:0], rq, int'(fault), ef);
    chk(err == ee, "R6 err_code", int'(err), int'(ee));
    chk(cs_sel == m_sel, "R7 cs_sel", int'(cs_sel), int'(m_sel));
    chk(cs_valid == m_valid, "R9 cs_valid", int'(cs_valid), int'(m_valid));
    chk(mode == m_mode, "R8 mode", int'(mode), int'(m_mode));
    chk(flush == (ef == 0), "R9 flush", int'(flush), int'(ef == 0));
    @(negedge clk);
    chk(!flush && !done, "R9 pulse width", int'({flush, done}), 0);
    chk(fault == ef[1:0], "R10 hold", int'(fault), ef);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    #1;
    chk(done == 0 && flush == 0 && cs_valid == 0 && cs_sel == 0 && mode == 0 && fault == 0,
        "R1 reset", int'({done, flush, cs_valid, mode, fault}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 success, CPL rewrites RPL bits, R8 legacy
    run(1,1,4'b1010,2'd1,1,0,1,16'h1233,2'd0,2'd1,0);
    // R2 invalid / system / data
    run(0,1,4'b1010,2'd0,1,0,0,16'h00ff,2'd0,2'd0,0);
    run(1,0,4'b1010,2'd0,1,0,0,16'h0abc,2'd0,2'd0,0);
    run(1,1,4'b0010,2'd0,1,0,0,16'h0abd,2'd0,2'd0,0);
    // R3 conflict with and without long mode
    run(1,1,4'b1010,2'd0,1,1,1,16'h4447,2'd0,2'd0,1);
    run(1,1,4'b1010,2'd0,1,1,1,16'h4447,2'd0,2'd0,0);
    // R4 non-conforming: dpl mismatch, rpl > cpl
    run(1,1,4'b1010,2'd2,1,0,0,16'h5555,2'd0,2'd1,0);
    run(1,1,4'b1010,2'd1,1,0,0,16'h5556,2'd3,2'd1,0);
    // R5 conforming: big rpl ok, dpl > cpl fault
    run(1,1,4'b1110,2'd0,1,0,0,16'h6662,2'd3,2'd2,0);
    run(1,1,4'b1110,2'd3,1,0,0,16'h6663,2'd0,2'd2,0);
    // R6 not-present ranks below privilege
    run(1,1,4'b1010,2'd3,0,0,0,16'h7777,2'd0,2'd1,0);
    run(1,1,4'b1010,2'd1,0,0,0,16'h7777,2'd0,2'd1,0);
    // R8 64-bit and compat
    run(1,1,4'b1010,2'd0,1,1,0,16'h8888,2'd0,2'd0,1);
    run(1,1,4'b1010,2'd0,1,0,1,16'h9999,2'd0,2'd0,1);
    for (int i = 0; i < 400; i++) begin
      logic [1:0] c;
      c = 2'($urandom_range(0, 3));
      run(($urandom % 8) != 0, ($urandom % 8) != 0,
          {($urandom % 6) != 0, 1'($urandom), 2'($urandom)},
          ($urandom % 2) ? c : 2'($urandom), ($urandom % 6) != 0,
          1'($urandom), ($urandom % 4) == 0, 16'($urandom),
          ($urandom % 2) ? 2'd0 : 2'($urandom), c, 1'($urandom));
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule